// File: doc/BRIEF.md
# Sequential Radix-4 Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits and returns their full `2W`-bit signed product. It handles two multiplier bits per clock. Each step looks at the lowest two multiplier bits still waiting, together with the bit just below them. An implied zero sits below the least significant bit for the first step. From those three bits the step picks one summand: zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. The summand is sign-extended and added to the upper half of the running partial product. The combined partial-product and multiplier register then shifts right arithmetically by two places. An operation therefore takes half as many add steps as there are multiplier bits, rounded up.

A client pulses `start` while the block is idle, with both operands on the inputs. `busy` stays high for the iteration cycles. `done` pulses for one cycle when the product is ready. The product stays on the output until the next accepted start. When `W` is odd, the multiplier is sign-extended by one bit so that the top pair still recodes correctly.

Top module: `radix4_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 captures `mcand` and `mplr`, and `busy` is 1 from the next cycle.
- R3: After an accepted start, `busy` stays high for exactly ceil(W/2) cycles. `done` rises in the same cycle that `busy` falls, and it is high for exactly one cycle.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a `2W`-bit two's-complement value. For example, 13 × −6 gives −78, which is 16'hFFB2 for W=8.
- R5: Each step takes the triple (multiplier bit i+1, bit i, bit i−1), with an implied 0 below bit 0. It adds the summand given by: 000→0, 001→+M, 010→+M, 011→+2M, 100→−2M, 101→−M, 110→−M, 111→0, where M is the multiplicand and negative summands are sign-extended two's complements.
- R6: Extreme operands produce exact products. For W=8: −128 × −128 = 16384, −128 × 127 = −16256, and 127 × 127 = 16129.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running operation keeps its operands and its cycle count.
- R8: While idle with `start` low, `product` holds its value, and changes on `mcand` and `mplr` have no effect on it.
- R9: For odd W, the multiplier is sign-extended by one bit before recoding, giving (W+1)/2 steps and exact signed products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mcand | input | W | Signed multiplicand |
| mplr | input | W | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 2W | Signed product |

## Verification
The bench builds two copies of the block. The first uses the default W=8, giving four steps. For it, every multiplicand is swept against a set of multipliers chosen to hit each recoding triple, the sign boundaries and the most negative value, and the sweep is repeated with the roles swapped. The second uses W=5, giving three steps. That width is odd, so it exercises the one-bit sign extension of the multiplier, and its full 1024-pair operand space is checked exhaustively.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

   typedef enum logic [2:0] {
      SEL_ZERO = 3'd0,
      SEL_P1   = 3'd1,
      SEL_P2   = 3'd2,
      SEL_M1   = 3'd3,
      SEL_M2   = 3'd4
   } summand_sel_e;

   // Map a (hi, lo, below) multiplier triple to a summand choice.
   function automatic summand_sel_e recode_triple(input logic [2:0] t);
      summand_sel_e s;
      case (t)
         3'b001, 3'b010: s = SEL_P1;
         3'b011:         s = SEL_P2;
         3'b100:         s = SEL_M2;
         3'b101, 3'b110: s = SEL_M1;
         default:        s = SEL_ZERO;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/r4m_recoder.sv
module r4m_recoder
   import r4m_pkg::*;
(
   input  logic [2:0]   triple,
   output summand_sel_e sel
);
   assign sel = recode_triple(triple);
endmodule

// File: rtl/r4m_summand.sv
module r4m_summand
   import r4m_pkg::*;
#(
   parameter int W = 8,
   localparam int SW = W + 2
)(
   input  logic [W-1:0]  mcand,
   input  summand_sel_e  sel,
   output logic [SW-1:0] summand
);
   logic signed [SW-1:0] one_m;
   logic signed [SW-1:0] two_m;

   assign one_m = {{2{mcand[W-1]}}, mcand};
   assign two_m = one_m <<< 1;

   always_comb begin
      case (sel)
         SEL_P1:  summand = one_m;
         SEL_P2:  summand = two_m;
         SEL_M1:  summand = -one_m;
         SEL_M2:  summand = -two_m;
         default: summand = '0;
      endcase
   end
endmodule

// File: rtl/r4m_ctrl.sv
module r4m_ctrl #(
   parameter int STEPS = 4,
   localparam int CW = $clog2(STEPS) + 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   logic [CW-1:0] cnt;

   assign load = start && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            cnt  <= '0;
            busy <= 1'b1;
         end else if (step) begin
            if (cnt == CW'(STEPS - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/r4m_datapath.sv
module r4m_datapath
   import r4m_pkg::*;
#(
   parameter int W = 8,
   localparam int QW = W + (W % 2),
   localparam int SW = W + 2,
   localparam int TW = SW + QW + 1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] mcand,
   input  logic [W-1:0] mplr,
   output logic [2*W-1:0] product
);
   logic [SW-1:0] acc_r;
   logic [QW-1:0] q_r;
   logic          qlow_r;
   logic [W-1:0]  m_r;
   logic [QW-1:0] mplr_ext;
   summand_sel_e  sel;
   logic [SW-1:0] summand;
   logic [SW-1:0] sum;
   logic [TW-1:0] pre_shift;
   logic [SW+QW-1:0] full;
   logic          unused_top;

   generate
      if (QW != W) begin : g_odd_ext
         assign mplr_ext = {mplr[W-1], mplr};
      end else begin : g_even_ext
         assign mplr_ext = mplr;
      end
   endgenerate

   r4m_recoder u_rec (
      .triple ({q_r[1:0], qlow_r}),
      .sel    (sel)
   );

   r4m_summand #(.W(W)) u_sum (
      .mcand   (m_r),
      .sel     (sel),
      .summand (summand)
   );

   assign sum       = acc_r + summand;
   assign pre_shift = {sum, q_r, qlow_r};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_r  <= '0;
         q_r    <= '0;
         qlow_r <= 1'b0;
         m_r    <= '0;
      end else if (load) begin
         acc_r  <= '0;
         q_r    <= mplr_ext;
         qlow_r <= 1'b0;
         m_r    <= mcand;
      end else if (step) begin
         {acc_r, q_r, qlow_r} <= TW'($signed(pre_shift) >>> 2);
      end
   end

   assign full       = {acc_r, q_r};
   assign product    = full[2*W-1:0];
   assign unused_top = ^full[SW+QW-1:2*W];
endmodule

// File: rtl/radix4_seq_mult.sv
module radix4_seq_mult #(
   parameter int W = 8,
   localparam int STEPS = (W + 1) / 2
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplr,
   output logic           busy,
   output logic           done,
   output logic [2*W-1:0] product
);
   generate
      if (W < 2) begin : g_bad_width
         $error("radix4_seq_mult: W must be at least 2");
      end
   endgenerate

   logic load;
   logic step;

   r4m_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   r4m_datapath #(.W(W)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .mcand   (mcand),
      .mplr    (mplr),
      .product (product)
   );
endmodule

// File: rtl/r4m_checker.sv
module r4m_checker #(
   parameter int W = 8,
   localparam int STEPS = (W + 1) / 2,
   localparam int CW = $clog2(STEPS) + 2
)(
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [W-1:0]   mcand,
   input logic [W-1:0]   mplr,
   input logic           busy,
   input logic           done,
   input logic [2*W-1:0] product
);
   logic [CW-1:0]         run_len;
   logic signed [W-1:0]   cap_a;
   logic signed [W-1:0]   cap_b;
   logic signed [2*W-1:0] ref_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
         cap_a   <= '0;
         cap_b   <= '0;
      end else begin
         run_len <= busy ? run_len + 1'b1 : '0;
         if (start && !busy) begin
            cap_a <= mcand;
            cap_b <= mplr;
         end
      end
   end

   assign ref_p = cap_a * cap_b;

   // R2
   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R3
   assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == CW'(STEPS)));
   // R4
   assert_product_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == ref_p));
   // R8
   assert_product_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

bind radix4_seq_mult r4m_checker #(.W(W)) u_r4m_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mcand   (mcand),
   .mplr    (mplr),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/tb_radix4_seq_mult.sv
module tb_radix4_seq_mult;
   localparam int CLK_PERIOD = 10;
   localparam int ITER8 = 4;
   localparam int ITER5 = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic        start8 = 1'b0;
   logic [7:0]  a8 = '0, b8 = '0;
   logic        busy8, done8;
   logic [15:0] p8;

   logic        start5 = 1'b0;
   logic [4:0]  a5 = '0, b5 = '0;
   logic        busy5, done5;
   logic [9:0]  p5;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   radix4_seq_mult #(.W(8)) dut (
      .clk(clk), .rst_n(rst_n), .start(start8), .mcand(a8), .mplr(b8),
      .busy(busy8), .done(done8), .product(p8));

   radix4_seq_mult #(.W(5)) dut_w5 (
      .clk(clk), .rst_n(rst_n), .start(start5), .mcand(a5), .mplr(b5),
      .busy(busy5), .done(done5), .product(p5));

   task automatic chk(input bit ok, input string req, input longint got, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   // Run one W=8 operation, checking handshake, latency and value.
   task automatic run8(input int a, input int b, input string req);
      logic signed [7:0]  sa, sb;
      logic signed [15:0] expv;
      int lat;
      sa = 8'(a); sb = 8'(b);
      expv = sa * sb;
      @(negedge clk); a8 = sa; b8 = sb; start8 = 1'b1;
      @(negedge clk); start8 = 1'b0;
      chk(busy8 === 1'b1, "R2 busy", busy8, 1);
      lat = 0;
      while (done8 !== 1'b1 && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == ITER8, "R3 latency", lat, ITER8);
      chk(busy8 === 1'b0, "R3 busy low at done", busy8, 0);
      chk($signed(p8) == expv, req, $signed(p8), expv);
      @(negedge clk);
      chk(done8 === 1'b0, "R3 done pulse", done8, 0);
   endtask

   task automatic run5(input int a, input int b);
      logic signed [4:0] sa, sb;
      logic signed [9:0] expv;
      int lat;
      sa = 5'(a); sb = 5'(b);
      expv = sa * sb;
      @(negedge clk); a5 = sa; b5 = sb; start5 = 1'b1;
      @(negedge clk); start5 = 1'b0;
      lat = 0;
      while (done5 !== 1'b1 && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == ITER5, "R9 latency W5", lat, ITER5);
      chk($signed(p5) == expv, "R9 product W5", $signed(p5), expv);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(busy8 === 1'b0, "R1 busy", busy8, 0);
      chk(done8 === 1'b0, "R1 done", done8, 0);
      chk(p8 === 16'h0, "R1 product", p8, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy8 === 1'b0 && p8 === 16'h0, "R1 after release", p8, 0);
   endtask

   task automatic t_worked;
      run8(13, -6, "R4 13*-6");
      chk(p8 === 16'hFFB2, "R4 encoding", p8, 16'hFFB2);
      run8(-6, 13, "R4 -6*13");
      run8(0, 0, "R4 zero");
   endtask

   // R5: multipliers chosen so the triples 000,001,010,011,100,101,110,111 all occur
   task automatic t_recode;
      int mult_set[10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h06, 8'h0C,
                           8'h55, 8'hAA, 8'hFF, 8'h9B};
      foreach (mult_set[i]) begin
         run8(13, mult_set[i], "R5 recode");
         run8(-77, mult_set[i], "R5 recode neg M");
      end
   endtask

   task automatic t_extremes;
      run8(-128, -128, "R6 -128*-128");
      chk(p8 === 16'h4000, "R6 16384", p8, 16'h4000);
      run8(-128, 127, "R6 -128*127");
      run8(127, -128, "R6 127*-128");
      run8(127, 127, "R6 127*127");
      run8(-1, -1, "R6 -1*-1");
   endtask

   task automatic t_busy_start;
      int lat;
      @(negedge clk); a8 = 8'd13; b8 = 8'hFA; start8 = 1'b1;
      @(negedge clk); a8 = 8'd100; b8 = 8'd100;
      @(negedge clk); start8 = 1'b0;
      lat = 1;
      while (done8 !== 1'b1 && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == ITER8, "R7 latency with extra start", lat, ITER8);
      chk($signed(p8) == -78, "R7 operands kept", $signed(p8), -78);
      @(negedge clk);
   endtask

   task automatic t_hold;
      run8(7, 9, "R8 setup");
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); a8 = 8'(k * 37 + 5); b8 = 8'(k * 91 + 3);
         @(negedge clk);
         chk(p8 === 16'd63, "R8 hold", p8, 63);
         chk(busy8 === 1'b0, "R8 idle", busy8, 0);
      end
   endtask

   task automatic t_sweep;
      int mset[16] = '{0, 1, -1, 2, -2, 3, 5, -6, 42, -43, 85, -86,
                       126, 127, -127, -128};
      foreach (mset[i]) begin
         for (int a = -128; a < 128; a++) begin
            run8(a, mset[i], "R4 sweep");
            run8(mset[i], a, "R4 sweep swapped");
         end
      end
   endtask

   task automatic t_odd;
      for (int a = -16; a < 16; a++)
         for (int b = -16; b < 16; b++)
            run5(a, b);
   endtask

   initial begin
      t_reset;
      t_worked;
      t_recode;
      t_extremes;
      t_busy_start;
      t_hold;
      t_odd;
      t_sweep;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule